// File: doc/BRIEF.md
# CAN Dedicated Receive Buffer Manager

This block takes the identifier of a received CAN frame and walks an ordered list of message ID filter elements, one element per clock, looking for the first element that matches. An element can send the frame to a dedicated receive buffer, divert it to a receive FIFO, or reject it. When a dedicated buffer is chosen, the block writes the frame words into that buffer's slot in message RAM. Once the last word is written, it sets the buffer's new-data flag and the store interrupt flag.

A buffer whose new-data flag is set is locked. Any element that points at a locked buffer counts as not matching, so the scan moves on to the later elements. The frame may then end up in another buffer, in the FIFO, or be rejected. The host reads the flags through a small register port and clears them by writing ones.

Top module: `rxbuf_mgr`

## Requirements
- R1: After reset, every new-data flag is 0, the interrupt flag is 0, `busy` is 0, and no RAM write occurs.
- R2: The element code 3'b111 targets a dedicated buffer only when bits [10:9] of the element's second ID field are 2'b00. In that case bits [5:0] of the same field give the buffer index. Code 3'b001 diverts the frame to the FIFO, code 3'b010 rejects it, and code 3'b000 and every other code never match.
- R3: An element's xtd bit must equal the frame's xtd bit. A standard element compares bits [10:0] of the first ID field with the frame ID bits [10:0]. An extended element compares all 29 bits.
- R4: The lowest-index matching element decides the outcome. If no element matches, `rejected` pulses for one cycle.
- R5: A dedicated store writes the frame words in order w = 0..EW-1. Word w goes to byte address {start_addr,2'b00} + 4*(idx*EW + w) and carries frm_data[32w+:32].
- R6: The new-data flag of a buffer reads 1 only from the second cycle after the cycle in which its last word is written. In both of the cycles in between, it still reads 0.
- R7: An element that points at a buffer whose flag is set does not match, and the scan continues with the next element.
- R8: Every dedicated store sets the interrupt flag.
- R9: Host register 0 holds flags 31..0 and register 1 holds flags 63..32. Register 2, bit 0, is the interrupt flag. Writing 1 to a bit clears that flag, and writing 0 has no effect.
- R10: When a host clear and a hardware set hit the same flag in the same cycle, the flag stays set. This applies to the new-data flags and to the interrupt flag.
- R11: A frame offered while `busy` is 1 is ignored.
- R12: A FIFO divert gives exactly one `to_fifo` pulse and no RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_addr | input | 14 | Word address of the dedicated-buffer area |
| flt_code | input | NF*3 | Element codes |
| flt_xtd | input | NF | Element extended-ID select |
| flt_id1 | input | NF*29 | Element match identifiers |
| flt_id2 | input | NF*11 | Element second ID fields |
| frm_valid | input | 1 | Frame offered (one cycle) |
| frm_xtd | input | 1 | Frame is extended |
| frm_id | input | 29 | Frame identifier |
| frm_data | input | EW*32 | Frame element words |
| busy | output | 1 | Scan or store in progress |
| ram_we | output | 1 | Message RAM write strobe |
| ram_addr | output | 16 | Message RAM byte address |
| ram_wdata | output | 32 | Message RAM write data |
| to_fifo | output | 1 | Frame diverted to FIFO |
| rejected | output | 1 | Frame rejected |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 2 | Host register select |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data |
| irq_drx | output | 1 | Dedicated-buffer store interrupt flag |

## Verification
If the lock state were wrong, a frame would overwrite a buffer that is still pending, or it would skip a buffer that is free. The bench sees this within one frame: the RAM writes land at the wrong slot, and the flag registers read back the wrong bit. If the scan order were wrong, the outcome pulse would be the wrong kind, visible a few cycles after the frame is offered. A wrong flag timing shows up in the exact cycle after the last word is written. A wrong clear path shows up in the next register read.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_STORE, ST_FIN} rx_state_e;
  typedef enum logic [1:0] {ACT_NONE, ACT_BUF, ACT_FIFO, ACT_REJ} flt_act_e;

  localparam logic [2:0] CODE_OFF  = 3'b000;
  localparam logic [2:0] CODE_FIFO = 3'b001;
  localparam logic [2:0] CODE_REJ  = 3'b010;
  localparam logic [2:0] CODE_DED  = 3'b111;

  // what an element would do if its identifier matched
  function automatic flt_act_e elem_action(input logic [2:0] code, input logic [10:0] id2);
    case (code)
      CODE_FIFO: return ACT_FIFO;
      CODE_REJ:  return ACT_REJ;
      CODE_DED:  return (id2[10:9] == 2'b00) ? ACT_BUF : ACT_NONE;
      default:   return ACT_NONE;
    endcase
  endfunction

  function automatic logic id_equal(input logic exd, input logic [28:0] eid,
                                    input logic fxd, input logic [28:0] fid);
    if (exd != fxd) return 1'b0;
    if (exd) return eid == fid;
    return eid[10:0] == fid[10:0];
  endfunction

  // byte address of word w of buffer slot idx
  function automatic logic [15:0] slot_byte_addr(input logic [13:0] start, input logic [5:0] idx,
                                                 input logic [31:0] w, input logic [31:0] ew);
    logic [31:0] off;
    off = ((32'(idx) * ew) + w) << 2;
    return {start, 2'b00} + off[15:0];
  endfunction
endpackage

// File: rtl/rxbuf_fscan.sv
module rxbuf_fscan import rxbuf_pkg::*; #(
  parameter int NF = 8,
  parameter int NB = 64,
  localparam int IW = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic [NF*3-1:0]  flt_code,
  input  logic [NF-1:0]    flt_xtd,
  input  logic [NF*29-1:0] flt_id1,
  input  logic [NF*11-1:0] flt_id2,
  input  logic [IW-1:0]    sel,
  input  logic             fxd,
  input  logic [28:0]      fid,
  input  logic [NB-1:0]    lock,
  output flt_act_e         act,
  output logic [5:0]       bidx,
  output logic             lock_skip
);
  logic [2:0]  code_a [NF];
  logic [28:0] id1_a  [NF];
  logic [10:0] id2_a  [NF];

  for (genvar k = 0; k < NF; k++) begin : g_unpack
    assign code_a[k] = flt_code[k*3 +: 3];
    assign id1_a[k]  = flt_id1[k*29 +: 29];
    assign id2_a[k]  = flt_id2[k*11 +: 11];
  end

  flt_act_e raw_act;
  logic     hit, tgt_locked;

  always_comb begin
    raw_act    = elem_action(code_a[sel], id2_a[sel]);
    hit        = id_equal(flt_xtd[sel], id1_a[sel], fxd, fid);
    bidx       = id2_a[sel][5:0];
    tgt_locked = (32'(bidx) >= NB) || lock[bidx[$clog2(NB)-1:0]];
    lock_skip  = hit && raw_act == ACT_BUF && tgt_locked;
    if (!hit || lock_skip) act = ACT_NONE;
    else                   act = raw_act;
  end
endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl import rxbuf_pkg::*; #(
  parameter int NF = 8,
  parameter int NB = 64,
  parameter int EW = 4,
  localparam int IW = (NF > 1) ? $clog2(NF) : 1,
  localparam int WW = (EW > 1) ? $clog2(EW) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [13:0]      start_addr,
  input  logic             frm_valid,
  input  logic             frm_xtd,
  input  logic [28:0]      frm_id,
  input  logic [EW*32-1:0] frm_data,
  input  flt_act_e         act,
  input  logic [5:0]       bidx,
  input  logic [NB-1:0]    lock,
  output logic [IW-1:0]    sel,
  output logic             cap_xtd,
  output logic [28:0]      cap_id,
  output logic             busy,
  output logic             ram_we,
  output logic [15:0]      ram_addr,
  output logic [31:0]      ram_wdata,
  output logic             to_fifo,
  output logic             rejected,
  output logic             set_en,
  output logic [5:0]       set_idx,
  output logic             last_we
);
  localparam logic [IW-1:0] LAST_ELEM = IW'(NF - 1);
  localparam logic [WW-1:0] LAST_WORD = WW'(EW - 1);

  rx_state_e        state;
  logic [EW*32-1:0] cap_data;
  logic [5:0]       buf_q;
  logic [WW-1:0]    wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sel      <= '0;
      cap_xtd  <= 1'b0;
      cap_id   <= '0;
      cap_data <= '0;
      buf_q    <= '0;
      wcnt     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (frm_valid) begin
          cap_xtd  <= frm_xtd;
          cap_id   <= frm_id;
          cap_data <= frm_data;
          sel      <= '0;
          state    <= ST_SCAN;
        end
        ST_SCAN: begin
          case (act)
            ACT_BUF: begin
              buf_q <= bidx;
              wcnt  <= '0;
              state <= ST_STORE;
            end
            ACT_FIFO, ACT_REJ: state <= ST_IDLE;
            default: begin
              if (sel == LAST_ELEM) state <= ST_IDLE;
              else                  sel   <= sel + 1'b1;
            end
          endcase
        end
        ST_STORE: begin
          if (wcnt == LAST_WORD) state <= ST_FIN;
          else                   wcnt  <= wcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = state != ST_IDLE;
    ram_we    = state == ST_STORE;
    ram_addr  = slot_byte_addr(start_addr, buf_q, 32'(wcnt), 32'(EW));
    ram_wdata = cap_data[32'(wcnt)*32 +: 32];
    last_we   = ram_we && wcnt == LAST_WORD;
    to_fifo   = state == ST_SCAN && act == ACT_FIFO;
    rejected  = state == ST_SCAN && (act == ACT_REJ || (act == ACT_NONE && sel == LAST_ELEM));
    set_en    = state == ST_FIN;
    set_idx   = buf_q;
  end

  // R5: words of one store go to consecutive addresses
  a_r5_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we && $past(ram_we) |-> ram_addr == $past(ram_addr) + 16'd4);
  // R7: a store never writes into a locked buffer
  a_r7_store_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !lock[buf_q[$clog2(NB)-1:0]]);
  // R4, R12: one outcome per scan step
  a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({to_fifo, rejected, ram_we && wcnt == '0}));
endmodule

// File: rtl/rxbuf_flags.sv
module rxbuf_flags #(
  parameter int NB = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [5:0]    set_idx,
  input  logic          last_we,
  input  logic          hst_wr,
  input  logic [1:0]    hst_addr,
  input  logic [31:0]   hst_wdata,
  output logic [31:0]   hst_rdata,
  output logic [NB-1:0] ndat,
  output logic          irq
);
  logic [63:0]   clr64, flags64;
  logic [NB-1:0] clr_vec, set_vec;
  logic          irq_clr;

  always_comb begin
    clr64 = '0;
    if (hst_wr && hst_addr == 2'd0) clr64[31:0]  = hst_wdata;
    if (hst_wr && hst_addr == 2'd1) clr64[63:32] = hst_wdata;
    clr_vec = clr64[NB-1:0];
    set_vec = '0;
    if (set_en && 32'(set_idx) < NB) set_vec[set_idx[$clog2(NB)-1:0]] = 1'b1;
    irq_clr = hst_wr && hst_addr == 2'd2 && hst_wdata[0];
    flags64 = 64'(ndat);
    case (hst_addr)
      2'd0:    hst_rdata = flags64[31:0];
      2'd1:    hst_rdata = flags64[63:32];
      2'd2:    hst_rdata = {31'd0, irq};
      default: hst_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ndat <= '0;
      irq  <= 1'b0;
    end else begin
      ndat <= (ndat & ~clr_vec) | set_vec;
      irq  <= (irq & ~irq_clr) | set_en;
    end
  end

  // R6: a flag is set only right after the last word was written
  a_r6_set_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> $past(last_we));
  // R8: the interrupt flag follows every store
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> irq);
  // R9: a flag only falls where the host wrote a 1
  a_r9_clear_only_written: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ndat) & ~ndat & ~$past(clr_vec)) == '0);
  // R10: a set in the same cycle as a clear still leaves the flag set
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_en && 32'(set_idx) < NB |=> ndat[$past(set_idx[$clog2(NB)-1:0])]);
endmodule

// File: rtl/rxbuf_mgr.sv
module rxbuf_mgr import rxbuf_pkg::*; #(
  parameter int NF = 8,
  parameter int NB = 64,
  parameter int EW = 4,
  localparam int IW = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [13:0]      start_addr,
  input  logic [NF*3-1:0]  flt_code,
  input  logic [NF-1:0]    flt_xtd,
  input  logic [NF*29-1:0] flt_id1,
  input  logic [NF*11-1:0] flt_id2,
  input  logic             frm_valid,
  input  logic             frm_xtd,
  input  logic [28:0]      frm_id,
  input  logic [EW*32-1:0] frm_data,
  output logic             busy,
  output logic             ram_we,
  output logic [15:0]      ram_addr,
  output logic [31:0]      ram_wdata,
  output logic             to_fifo,
  output logic             rejected,
  input  logic             hst_wr,
  input  logic [1:0]       hst_addr,
  input  logic [31:0]      hst_wdata,
  output logic [31:0]      hst_rdata,
  output logic             irq_drx
);
  flt_act_e      act;
  logic [5:0]    bidx, set_idx;
  logic          lock_skip, set_en, last_we, cap_xtd;
  logic [28:0]   cap_id;
  logic [IW-1:0] sel;
  logic [NB-1:0] ndat;

  rxbuf_fscan #(.NF(NF), .NB(NB)) u_scan (
    .flt_code(flt_code), .flt_xtd(flt_xtd), .flt_id1(flt_id1), .flt_id2(flt_id2),
    .sel(sel), .fxd(cap_xtd), .fid(cap_id), .lock(ndat),
    .act(act), .bidx(bidx), .lock_skip(lock_skip)
  );

  rxbuf_ctrl #(.NF(NF), .NB(NB), .EW(EW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr),
    .frm_valid(frm_valid), .frm_xtd(frm_xtd), .frm_id(frm_id), .frm_data(frm_data),
    .act(act), .bidx(bidx), .lock(ndat), .sel(sel), .cap_xtd(cap_xtd), .cap_id(cap_id),
    .busy(busy), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .to_fifo(to_fifo), .rejected(rejected), .set_en(set_en), .set_idx(set_idx),
    .last_we(last_we)
  );

  rxbuf_flags #(.NB(NB)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_idx(set_idx), .last_we(last_we),
    .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .ndat(ndat), .irq(irq_drx)
  );

  // R7: a locked target never starts a store in the next cycle
  a_r7_skip_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    lock_skip && busy && !ram_we |=> !(ram_we && !$past(ram_we)));
endmodule

// File: tb/tb_rxbuf_mgr.sv
module tb_rxbuf_mgr;
  localparam int NF = 8;
  localparam int NB = 64;
  localparam int EW = 4;
  localparam logic [13:0] START = 14'h0100;
  localparam logic [15:0] BASE  = {START, 2'b00};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NF*3-1:0] flt_code; logic [NF-1:0] flt_xtd;
  logic [NF*29-1:0] flt_id1; logic [NF*11-1:0] flt_id2;
  logic frm_valid = 0, frm_xtd = 0; logic [28:0] frm_id = 0; logic [EW*32-1:0] frm_data = 0;
  logic busy, ram_we, to_fifo, rejected, irq_drx;
  logic [15:0] ram_addr; logic [31:0] ram_wdata, hst_rdata;
  logic hst_wr = 0; logic [1:0] hst_addr = 0; logic [31:0] hst_wdata = 0;

  rxbuf_mgr #(.NF(NF), .NB(NB), .EW(EW)) dut (
    .clk(clk), .rst_n(rst_n), .start_addr(START), .flt_code(flt_code), .flt_xtd(flt_xtd),
    .flt_id1(flt_id1), .flt_id2(flt_id2), .frm_valid(frm_valid), .frm_xtd(frm_xtd),
    .frm_id(frm_id), .frm_data(frm_data), .busy(busy), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .to_fifo(to_fifo), .rejected(rejected), .hst_wr(hst_wr),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .irq_drx(irq_drx)
  );

  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, fifo_cnt = 0, rej_cnt = 0;
  logic [31:0] mem [NB*EW];
  logic [63:0] exp_ndat = '0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (ram_we) begin
      wr_cnt++;
      if (ram_addr >= BASE && ram_addr < BASE + 16'(NB*EW*4))
        mem[(ram_addr - BASE) >> 2] = ram_wdata;
    end
    if (to_fifo)  fifo_cnt++;
    if (rejected) rej_cnt++;
  end

  function automatic logic [31:0] dword(input int f, input int w);
    return {8'(f), 8'(w), 16'h5A3C};
  endfunction

  task automatic send(input logic x, input logic [28:0] id, input int f);
    @(negedge clk);
    frm_valid = 1; frm_xtd = x; frm_id = id;
    for (int w = 0; w < EW; w++) frm_data[w*32 +: 32] = dword(f, w);
    @(negedge clk);
    frm_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    hst_addr = a; #1; d = hst_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_wr = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 0;
  endtask

  task automatic check_flags(input string req);
    logic [31:0] lo, hi;
    rd(2'd0, lo); rd(2'd1, hi);
    check(req, {hi, lo}, exp_ndat);
  endtask

  task automatic check_slot(input string req, input int b, input int f);
    for (int w = 0; w < EW; w++) check(req, 64'(mem[b*EW + w]), 64'(dword(f, w)));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // kind: 0 dedicated buffer, 1 FIFO, 2 reject
  typedef struct packed { logic xtd; logic [28:0] id; logic [1:0] kind; logic [5:0] bidx; } vec_t;
  localparam vec_t VECS [9] = '{
    '{1'b0, 29'h123,     2'd0, 6'd0},   // R2 R3 first element
    '{1'b0, 29'h123,     2'd0, 6'd5},   // R7 buf 0 locked -> element 1
    '{1'b0, 29'h123,     2'd1, 6'd0},   // R7 R12 both locked -> FIFO
    '{1'b1, 29'h1ABCDE0, 2'd0, 6'd63},  // R3 extended, R5 top slot
    '{1'b1, 29'h1ABCDE0, 2'd2, 6'd0},   // R4 R7 locked, nothing later -> reject
    '{1'b0, 29'h200,     2'd2, 6'd0},   // R2 reject code
    '{1'b0, 29'h300,     2'd1, 6'd0},   // R2 111 with [10:9]!=00 skipped
    '{1'b0, 29'h400,     2'd2, 6'd0},   // R2 disabled element, R4 no match
    '{1'b1, 29'h123,     2'd2, 6'd0}    // R3 xtd mismatch
  };

  initial begin
    logic [31:0] d;
    int w0, f0, r0;
    flt_code = '0; flt_xtd = '0; flt_id1 = '0; flt_id2 = '0;
    flt_code[0*3 +: 3] = 3'b111; flt_id1[0*29 +: 29] = 29'h123; flt_id2[0*11 +: 11] = 11'd0;
    flt_code[1*3 +: 3] = 3'b111; flt_id1[1*29 +: 29] = 29'h123; flt_id2[1*11 +: 11] = 11'd5;
    flt_code[2*3 +: 3] = 3'b001; flt_id1[2*29 +: 29] = 29'h123;
    flt_code[3*3 +: 3] = 3'b111; flt_id1[3*29 +: 29] = 29'h1ABCDE0; flt_id2[3*11 +: 11] = 11'd63;
    flt_xtd[3] = 1'b1;
    flt_code[4*3 +: 3] = 3'b010; flt_id1[4*29 +: 29] = 29'h200;
    flt_code[5*3 +: 3] = 3'b111; flt_id1[5*29 +: 29] = 29'h300; flt_id2[5*11 +: 11] = 11'h201;
    flt_code[6*3 +: 3] = 3'b001; flt_id1[6*29 +: 29] = 29'h300;
    flt_code[7*3 +: 3] = 3'b000; flt_id1[7*29 +: 29] = 29'h400;
    for (int i = 0; i < NB*EW; i++) mem[i] = '0;

    repeat (3) @(negedge clk);
    // R1 reset state
    check_flags("R1 flags");
    rd(2'd2, d); check("R1 irq", 64'(d), 64'd0);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 no write", 64'(wr_cnt), 64'd0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 9; i++) begin
      w0 = wr_cnt; f0 = fifo_cnt; r0 = rej_cnt;
      send(VECS[i].xtd, VECS[i].id, i + 1);
      wait_idle();
      @(negedge clk);
      case (VECS[i].kind)
        2'd0: begin
          check("R5 word count", 64'(wr_cnt - w0), 64'(EW));
          check_slot("R5 slot data", int'(VECS[i].bidx), i + 1);
          exp_ndat[VECS[i].bidx] = 1'b1;
          rd(2'd2, d); check("R8 irq set", 64'(d), 64'd1);
        end
        2'd1: begin
          check("R12 fifo pulse", 64'(fifo_cnt - f0), 64'd1);
          check("R12 no write", 64'(wr_cnt - w0), 64'd0);
        end
        default: begin
          check("R4 reject pulse", 64'(rej_cnt - r0), 64'd1);
          check("R4 no write", 64'(wr_cnt - w0), 64'd0);
        end
      endcase
      check_flags("R7 flag bank");
    end

    // R9 writing zeros changes nothing
    wr(2'd0, 32'd0); wr(2'd1, 32'd0);
    check_flags("R9 zero write");
    // R9 clear buf 0 and buf 63
    wr(2'd0, 32'd1); wr(2'd1, 32'h8000_0000);
    exp_ndat[0] = 0; exp_ndat[63] = 0;
    check_flags("R9 w1c");
    wr(2'd2, 32'd1);
    rd(2'd2, d); check("R9 irq w1c", 64'(d), 64'd0);

    // R6 flag timing relative to the last word
    send(1'b0, 29'h123, 20);
    while (!(ram_we && ram_addr == BASE + 16'd12)) @(negedge clk);
    rd(2'd0, d); check("R6 flag low at last write", 64'(d[0]), 64'd0);
    @(negedge clk);
    rd(2'd0, d); check("R6 flag low one cycle later", 64'(d[0]), 64'd0);
    @(negedge clk);
    rd(2'd0, d); check("R6 flag high", 64'(d[0]), 64'd1);
    check_slot("R6 data", 0, 20);
    exp_ndat[0] = 1;

    // R11 frame during busy is ignored
    wr(2'd0, 32'd1); exp_ndat[0] = 0;
    r0 = rej_cnt;
    send(1'b0, 29'h123, 21);
    send(1'b0, 29'h200, 22);
    wait_idle();
    repeat (2) @(negedge clk);
    check("R11 ignored frame", 64'(rej_cnt - r0), 64'd0);
    exp_ndat[0] = 1;
    check_flags("R11 flags");

    // R10 clear of buf 0 in the same cycle as its set
    wr(2'd0, 32'd1);
    send(1'b0, 29'h123, 23);
    while (!(ram_we && ram_addr == BASE + 16'd12)) @(negedge clk);
    @(negedge clk);
    hst_wr = 1; hst_addr = 2'd0; hst_wdata = 32'd1;
    @(negedge clk);
    hst_wr = 0;
    check_flags("R10 set wins flag");

    // R10 irq clear in the same cycle as its set
    wr(2'd0, 32'd1); wr(2'd2, 32'd1);
    send(1'b0, 29'h123, 24);
    while (!(ram_we && ram_addr == BASE + 16'd12)) @(negedge clk);
    @(negedge clk);
    hst_wr = 1; hst_addr = 2'd2; hst_wdata = 32'd1;
    @(negedge clk);
    hst_wr = 0;
    rd(2'd2, d); check("R10 set wins irq", 64'(d), 64'd1);

    finish_run();
  end
endmodule